// File: doc/BRIEF.md
# Glitch-Free Runtime Clock Prescaler

This block divides a fast, undivided source clock down to the system clock that feeds the core and its synchronous peripherals. Software may pick a new division ratio at any moment through a small write port. The output is produced as a register in the source-clock domain. A change of ratio therefore never creates a runt pulse, and no output period is ever shorter than the shorter of the old and the new periods. A registered clock-out copy is also provided, and it can be switched off.

A ratio change takes effect only at a period boundary. The period in progress always runs to its end. The next period then runs at the longer of the old and new lengths. All periods after that one use the new ratio. Oscillator choice, trimming and default storage are outside this block: the reset-time ratio comes from a static input.

Top module: `clkp_top`

## Requirements
- R1: While reset is high, sys_clk and ckout are 0 and rd_data equals rst_code. rst_code must be a legal code; a reserved one is clamped to code 7. The first rising sys_clk edge occurs on the first source edge after reset is released. The first period uses the rst_code ratio.
- R2: With code c (0..7) active, every sys_clk period is 2^(c+1) source cycles long, with exactly 2^c cycles high followed by 2^c cycles low.
- R3: A write with wr_en high and wr_data in 0..7 is accepted. rd_data shows that value from the edge that samples the write.
- R4: A write of a reserved code (8..15) is ignored. rd_data does not change, and the sys_clk periods are unaffected.
- R5: Take a write accepted at source edge w, and a sys_clk period that starts at rising edge R with R >= w+2. The first such period has the length of the longer of the old and new ratios, and is half high and half low. Every period after it has the new length. Periods that start earlier are not affected.
- R6: When several accepted writes have all reached the same period boundary, only the last of them counts as the new ratio.
- R7: When ckout_en has been high for at least one cycle, ckout equals sys_clk. When ckout_en has been low for at least one cycle, ckout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Undivided source clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_code | input | 4 | Static divide-select code used at reset |
| wr_en | input | 1 | Write strobe for the divide-select value |
| wr_data | input | 4 | Divide-select code to write |
| rd_data | output | 4 | Most recently accepted divide-select code |
| ckout_en | input | 1 | Enables the clock-out copy |
| sys_clk | output | 1 | Divided system clock, registered |
| ckout | output | 1 | Gated, registered copy of sys_clk |

## Verification
A wrong counter or a stale stored half-period shows at the ports within one output period. Such an error makes a high phase, a low phase or a whole period that differs from 2^c or 2^(c+1). This can be seen no later than 256 source cycles after the fault. A pending request that is lost, or taken at the wrong boundary, shows as a period of the wrong length. The bench would see the transition period missing, doubled or shifted by one period on the first rising edge after the write. A read-back register that takes reserved codes shows up on the very next cycle.

// File: rtl/clkp_pkg.sv
package clkp_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_CODE = 7;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } clkp_req_t;
endpackage

// File: rtl/clkp_regs.sv
module clkp_regs
  import clkp_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int MAXC = MAX_CODE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_code,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          ack,
  output logic          pend_v,
  output logic [CW-1:0] pend_code,
  output logic [CW-1:0] rd_data
);
  localparam logic [CW-1:0] LIMIT = CW'(MAXC);

  logic legal;
  assign legal = wr_en && (wr_data <= LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_code <= init_code;
      rd_data   <= init_code;
    end else if (legal) begin
      pend_v    <= 1'b1;
      pend_code <= wr_data;
      rd_data   <= wr_data;
    end else if (ack) begin
      pend_v    <= 1'b0;
    end
  end

  assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data <= LIMIT)) |=> (rd_data == $past(wr_data)));

  assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data > LIMIT)) |=> $stable(rd_data));
endmodule

// File: rtl/clkp_switch.sv
module clkp_switch
  import clkp_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int MAXC = MAX_CODE,
  parameter int HW   = MAX_CODE + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_code,
  input  logic          boundary,
  input  logic          pend_v,
  input  logic [CW-1:0] pend_code,
  output logic          ack,
  output logic [CW-1:0] cur_code,
  output logic [HW-1:0] init_half,
  output logic [HW-1:0] next_half
);
  function automatic logic [HW-1:0] half_of(input logic [CW-1:0] c);
    half_of = {{(HW-1){1'b0}}, 1'b1} << c;
  endfunction

  logic [HW-1:0] cur_half, req_half;

  assign cur_half  = half_of(cur_code);
  assign req_half  = half_of(pend_code);
  assign init_half = half_of(init_code);
  assign ack       = boundary && pend_v;

  always_comb begin
    if (pend_v)
      next_half = (req_half > cur_half) ? req_half : cur_half;
    else
      next_half = cur_half;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cur_code <= init_code;
    else if (ack)
      cur_code <= pend_code;
  end

  assert_next_pow2_R2: assert property (@(posedge clk) disable iff (rst)
    boundary |-> $onehot(next_half));
endmodule

// File: rtl/clkp_divider.sv
module clkp_divider
  import clkp_pkg::*;
#(
  parameter int HW = MAX_CODE + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] init_half,
  input  logic [HW-1:0] next_half,
  output logic          boundary,
  output logic          phase,
  output logic          sys_clk_o
);
  logic [HW-1:0] cnt;
  logic [HW-1:0] half;
  logic [HW:0]   last;

  assign last     = {half, 1'b0} - {{HW{1'b0}}, 1'b1};
  assign boundary = ({1'b0, cnt} == last);
  assign phase    = (cnt < half);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      half      <= init_half;
      sys_clk_o <= 1'b0;
    end else begin
      sys_clk_o <= phase;
      if (boundary) begin
        cnt  <= '0;
        half <= next_half;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

  assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_clk_o) |-> (cnt == {{(HW-1){1'b0}}, 1'b1}));

  assert_half_pow2_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(half));

  assert_half_only_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(half));
endmodule

// File: rtl/clkp_ckout.sv
module clkp_ckout (
  input  logic clk,
  input  logic rst,
  input  logic phase,
  input  logic en,
  output logic ckout_o
);
  always_ff @(posedge clk) begin
    if (rst) ckout_o <= 1'b0;
    else     ckout_o <= en & phase;
  end

  assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ckout_o);
endmodule

// File: rtl/clkp_top.sv
module clkp_top
  import clkp_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int MAXC = MAX_CODE
) (
  input  logic          clk_src,
  input  logic          rst,
  input  logic [CW-1:0] rst_code,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  input  logic          ckout_en,
  output logic          sys_clk,
  output logic          ckout
);
  localparam int HW = MAXC + 1;
  localparam logic [CW-1:0] LIMIT = CW'(MAXC);

  logic [CW-1:0] init_code;
  logic [HW-1:0] init_half, next_half;
  logic          boundary, phase, ack;
  clkp_req_t     req;
  logic [CW-1:0] cur_code;

  assign init_code = (rst_code > LIMIT) ? LIMIT : rst_code;

  clkp_regs #(.CW(CW), .MAXC(MAXC)) u_regs (
    .clk(clk_src), .rst(rst), .init_code(init_code),
    .wr_en(wr_en), .wr_data(wr_data), .ack(ack),
    .pend_v(req.valid), .pend_code(req.code), .rd_data(rd_data)
  );

  clkp_switch #(.CW(CW), .MAXC(MAXC), .HW(HW)) u_switch (
    .clk(clk_src), .rst(rst), .init_code(init_code),
    .boundary(boundary), .pend_v(req.valid), .pend_code(req.code),
    .ack(ack), .cur_code(cur_code),
    .init_half(init_half), .next_half(next_half)
  );

  clkp_divider #(.HW(HW)) u_div (
    .clk(clk_src), .rst(rst), .init_half(init_half), .next_half(next_half),
    .boundary(boundary), .phase(phase), .sys_clk_o(sys_clk)
  );

  clkp_ckout u_ck (
    .clk(clk_src), .rst(rst), .phase(phase), .en(ckout_en), .ckout_o(ckout)
  );

  assert_active_matches_readback_R5: assert property (@(posedge clk_src) disable iff (rst)
    !req.valid |-> (cur_code == rd_data));
endmodule

// File: tb/sim_clkp_top.sv
module sim_clkp_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rst_code = 4'd3;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] rd_data;
  logic       ckout_en = 1'b0;
  logic       sys_clk, ckout;

  always #4 clk = ~clk;

  clkp_top u0 (
    .clk_src(clk), .rst(rst), .rst_code(rst_code), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ckout_en(ckout_en), .sys_clk(sys_clk), .ckout(ckout)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int rel_edge = 0;
  string tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int per_of(input int c);
    return 2 << c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  int q_code[$];
  int q_edge[$];
  int model_cur = 3;
  int exp_rd = 3;
  int exp_len = 0;
  int last_rise = 0;
  int high_len = 0;
  bit have_rise = 0;
  bit prev_s = 0;
  int en_chk = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sys_clk && !prev_s) begin
        if (have_rise) begin
          check(tag, cyc - last_rise, exp_len);
          check(tag, high_len, exp_len / 2);
        end else begin
          check("R1", cyc, rel_edge);
        end
        begin
          int tgt = -1;
          while (q_edge.size() > 0 && q_edge[0] <= cyc - 2) begin
            tgt = q_code[0];
            void'(q_code.pop_front());
            void'(q_edge.pop_front());
          end
          if (tgt >= 0) begin
            exp_len = (per_of(tgt) > per_of(model_cur)) ? per_of(tgt) : per_of(model_cur);
            model_cur = tgt;
          end else begin
            exp_len = per_of(model_cur);
          end
        end
        last_rise = cyc;
        have_rise = 1;
      end
      if (!sys_clk && prev_s) high_len = cyc - last_rise;
      if (en_chk == 1) check("R7", int'(ckout), int'(sys_clk));
      if (en_chk == 2) check("R7", int'(ckout), 0);
      prev_s = sys_clk;
    end
  end

  task automatic do_write(input int code, input string req);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 4'(code);
    @(negedge clk);
    wr_en = 1'b0;
    if (code <= 7) begin
      q_code.push_back(code);
      q_edge.push_back(cyc);
      exp_rd = code;
    end
    check(req, int'(rd_data), exp_rd);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1", int'(sys_clk), 0);
    check("R1", int'(ckout), 0);
    check("R1", int'(rd_data), 3);
    rst = 1'b0;
    rel_edge = cyc + 1;
    idle(40);

    tag = "R5"; do_write(0, "R3"); idle(30);
    tag = "R5"; do_write(7, "R3"); idle(800);
    tag = "R5"; do_write(1, "R3"); idle(300);

    tag = "R4"; do_write(12, "R4"); do_write(9, "R4"); idle(40);
    check("R4", int'(rd_data), 1);

    tag = "R6"; do_write(5, "R6"); do_write(2, "R6"); idle(300);

    tag = "R7";
    @(negedge clk); ckout_en = 1'b1; idle(2); en_chk = 1; idle(60);
    en_chk = 0; ckout_en = 1'b0; idle(2); en_chk = 2; idle(60); en_chk = 0;

    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      int c = int'($urandom % 16);
      if (c > 7) tag = "R4"; else tag = "R5";
      do_write(c, (c > 7) ? "R4" : "R3");
      idle(int'($urandom % 400));
    end
    tag = "R2";
    idle(1200);
    finish_run();
  end
endmodule